// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block owns all refresh traffic for an asynchronous DRAM array that uses a multiplexed row/column address bus and four bank strobes. After reset it stays silent through a power-up settling window. It then runs a fixed number of warm-up refresh cycles. Once warm-up ends it asks for one refresh slot per interval, so that every row is revisited inside the retention budget. All timing limits are given in nanoseconds and converted to whole clock cycles. Minimum widths round up. The refresh interval rounds down, so that it is never too long.

The block shares the DRAM pins with an access sequencer through a request/grant pair. While it holds the grant it drives the row strobes, column strobes, write enable and address. Two refresh styles are available, chosen per cycle by an input. In the first style the column strobe leads the row strobe. In the second, only the row strobe toggles, and an internal row counter supplies the address. Slots that cannot be served at once are kept in a backlog count, and a sticky flag records that the backlog ever went past its limit.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is low and on the first cycle after it: `req`=0, `init_done`=0, `drive_en`=0, every `ras_n` and `cas_n` bit =1, `we_n`=1, `addr`=0, `pend_cnt`=0 and `missed`=0.
- R2: After reset is released, `req` stays low for exactly PWR_C=ceil(POWERUP_NS/CLK_NS) clock edges. It is first seen high after edge PWR_C.
- R3: Exactly INIT_CYC refresh cycles are issued before `init_done` rises. The interval timer does not run before then, so `pend_cnt` stays 0.
- R4: A refresh starts on the edge after `req` and `grant` are both high. `req` stays high through the precharge. While the block is not in a sequence, `drive_en`=0 and all strobes are high. With the grant held and work pending, row-strobe falls follow each other every SETUP_C+RASLO_C+PRE_C+1 cycles.
- R5: In the column-first style (`ras_only`=0 at the start), `cas_n` falls at least SETUP_C=max(1,ceil(tCSR),ceil(tASR)) cycles before `ras_n` falls and stays low until `ras_n` rises. `we_n` stays 1 throughout.
- R6: In the row-only style (`ras_only`=1 at the start), `cas_n` stays high and `addr` carries the row counter, held steady while `ras_n` is low. The counter advances by one after each row-only refresh and wraps from 2^ROW_W-1 to 0.
- R7: All NUM_RAS row strobes switch together, and so do all column strobes.
- R8: `ras_n` stays low for exactly RASLO_C=max(ceil(tRAS),ceil(tCHR),ceil(tRC)-ceil(tRP)) cycles. It stays high for at least PRE_C=ceil(tRP) cycles, and successive falls are at least ceil(tRC) cycles apart.
- R9: After `init_done`, one refresh slot is added every REFI_C=floor(REFI_NS/CLK_NS) cycles. When the grant follows the request at once, successive row-strobe falls are exactly REFI_C cycles apart.
- R10: `pend_cnt` rises by one for each slot added and falls by one for each completed refresh after warm-up. It changes by at most one per cycle and saturates at its all-ones value.
- R11: `missed` goes to 1 one cycle after `pend_cnt` first exceeds BACKLOG_MAX and stays 1 until reset.
- R12: `ras_only` is sampled only on the edge that starts a sequence (0 = column-first, 1 = row-only), and the whole sequence follows that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Pin ownership from the arbiter |
| ras_only | input | 1 | Refresh style for the next sequence (1 = row-only) |
| req | output | 1 | Request for the DRAM pins |
| init_done | output | 1 | Warm-up complete; normal traffic allowed |
| drive_en | output | 1 | Block is driving the DRAM pins |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_RAS | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Multiplexed address (row counter in row-only style) |
| pend_cnt | output | PEND_W | Refresh slots waiting for service |
| missed | output | 1 | Sticky: backlog exceeded BACKLOG_MAX |

## Verification
The assertions assume that the arbiter keeps `grant` high for as long as `drive_en` is high, and that it never revokes ownership in the middle of a sequence. The bench's grant model meets this assumption: it re-registers `grant` from `req` on every falling edge, so the grant can only drop after the block has dropped its request. The bench changes `ras_only` only while the block is idle with no request up, so each sequence sees a single style. To build a backlog, the bench withholds the grant only between sequences.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_RASLO,
    SQ_PRE
  } seq_state_e;

  // Minimum-width limit: round up to whole cycles.
  function automatic int ns_to_cyc_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // Maximum-interval limit: round down so the budget is never exceeded.
  function automatic int ns_to_cyc_dn(input int ns, input int clk_ns);
    return ns / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Next backlog value: +1 per slot, -1 per service, saturating at both ends.
  function automatic int pend_step(input int cur, input bit add, input bit sub, input int top);
    int nxt;
    nxt = cur;
    if (add && !sub && cur < top) nxt = cur + 1;
    if (sub && !add && cur > 0)   nxt = cur - 1;
    return nxt;
  endfunction

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase #(
  parameter int PWR_C  = 2,
  parameter int REFI_C = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pwr_done,
  output logic tick
);
  localparam int PW = $clog2(PWR_C + 1);
  localparam int IW = $clog2(REFI_C + 1);

  logic [PW-1:0] pcnt;
  logic [IW-1:0] icnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt     <= '0;
      pwr_done <= 1'b0;
      icnt     <= '0;
    end else begin
      if (!pwr_done) begin
        if (pcnt == PW'(PWR_C - 1)) pwr_done <= 1'b1;
        else                        pcnt     <= pcnt + 1'b1;
      end
      if (!run || icnt == IW'(REFI_C - 1)) icnt <= '0;
      else                                 icnt <= icnt + 1'b1;
    end
  end

  assign tick = run && (icnt == IW'(REFI_C - 1));

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
  import dram_rfsh_pkg::*;
#(
  parameter int PEND_W      = 4,
  parameter int BACKLOG_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              served,
  output logic [PEND_W-1:0] pend,
  output logic              missed
);
  localparam int TOP = (1 << PEND_W) - 1;

  logic [PEND_W-1:0] pend_nxt;
  assign pend_nxt = PEND_W'(pend_step(int'(pend), tick, served, TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      missed <= 1'b0;
    end else begin
      pend   <= pend_nxt;
      missed <= missed | (pend > PEND_W'(BACKLOG_MAX));
    end
  end

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import dram_rfsh_pkg::*;
#(
  parameter int SETUP_C = 1,
  parameter int RASLO_C = 4,
  parameter int PRE_C   = 2,
  parameter int ROW_W   = 11,
  parameter int NUM_RAS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               ras_only,
  output logic               busy,
  output logic               done,
  output logic               mode_ro,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_RAS-1:0] cas_n,
  output logic               we_n,
  output logic [ROW_W-1:0]   addr
);
  localparam int LONGEST = max2(SETUP_C, max2(RASLO_C, PRE_C));
  localparam int CW      = $clog2(LONGEST + 1);

  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] row;
  logic             ras_lo, cas_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      mode_ro <= 1'b0;
      row     <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          state   <= SQ_SETUP;
          cnt     <= CW'(SETUP_C - 1);
          mode_ro <= ras_only;
        end
        SQ_SETUP: if (cnt == '0) begin
          state <= SQ_RASLO;
          cnt   <= CW'(RASLO_C - 1);
        end else cnt <= cnt - 1'b1;
        SQ_RASLO: if (cnt == '0) begin
          state <= SQ_PRE;
          cnt   <= CW'(PRE_C - 1);
        end else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
          state <= SQ_IDLE;
          if (mode_ro) row <= row + 1'b1;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy   = (state != SQ_IDLE);
  assign done   = (state == SQ_PRE) && (cnt == '0);
  assign ras_lo = (state == SQ_RASLO);
  assign cas_lo = !mode_ro && (state == SQ_SETUP || state == SQ_RASLO);
  assign we_n   = 1'b1;
  assign addr   = (busy && mode_ro) ? row : '0;

  for (genvar g = 0; g < NUM_RAS; g++) begin : g_strobe
    assign ras_n[g] = !ras_lo;
    assign cas_n[g] = !cas_lo;
  end

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int POWERUP_NS  = 200000,
  parameter int REFI_NS     = 15600,
  parameter int T_RP_NS     = 40,
  parameter int T_RAS_NS    = 60,
  parameter int T_RC_NS     = 110,
  parameter int T_CSR_NS    = 10,
  parameter int T_CHR_NS    = 10,
  parameter int T_ASR_NS    = 0,
  parameter int INIT_CYC    = 8,
  parameter int ROW_W       = 11,
  parameter int NUM_RAS     = 4,
  parameter int PEND_W      = 4,
  parameter int BACKLOG_MAX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               grant,
  input  logic               ras_only,
  output logic               req,
  output logic               init_done,
  output logic               drive_en,
  output logic [NUM_RAS-1:0] ras_n,
  output logic [NUM_RAS-1:0] cas_n,
  output logic               we_n,
  output logic [ROW_W-1:0]   addr,
  output logic [PEND_W-1:0]  pend_cnt,
  output logic               missed
);
  localparam int PWR_C   = max2(1, ns_to_cyc_up(POWERUP_NS, CLK_NS));
  localparam int REFI_C  = max2(2, ns_to_cyc_dn(REFI_NS, CLK_NS));
  localparam int PRE_C   = max2(1, ns_to_cyc_up(T_RP_NS, CLK_NS));
  localparam int SETUP_C = max2(1, max2(ns_to_cyc_up(T_CSR_NS, CLK_NS),
                                        ns_to_cyc_up(T_ASR_NS, CLK_NS)));
  localparam int RASLO_C = max2(1, max2(max2(ns_to_cyc_up(T_RAS_NS, CLK_NS),
                                             ns_to_cyc_up(T_CHR_NS, CLK_NS)),
                                        ns_to_cyc_up(T_RC_NS, CLK_NS) - PRE_C));
  localparam int INIT_W  = $clog2(INIT_CYC + 1) + 1;

  // Named internal events (observed by the bound checker).
  logic              pwr_done, tick, seq_start, seq_done, seq_busy, mode_ro;
  logic              need, init_left_nz;
  logic [INIT_W-1:0] init_left;

  always_ff @(posedge clk) begin
    if (!rst_n)                          init_left <= INIT_W'(INIT_CYC);
    else if (seq_done && init_left_nz)   init_left <= init_left - 1'b1;
  end

  assign init_left_nz = (init_left != '0);
  assign init_done    = pwr_done && !init_left_nz;
  assign need         = pwr_done && (init_left_nz || pend_cnt != '0);
  assign req          = seq_busy || need;
  assign seq_start    = !seq_busy && need && grant;
  assign drive_en     = seq_busy;

  rfsh_timebase #(.PWR_C(PWR_C), .REFI_C(REFI_C)) u_time (
    .clk(clk), .rst_n(rst_n), .run(init_done),
    .pwr_done(pwr_done), .tick(tick)
  );

  rfsh_backlog #(.PEND_W(PEND_W), .BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .served(seq_done && !init_left_nz),
    .pend(pend_cnt), .missed(missed)
  );

  rfsh_strobe_seq #(
    .SETUP_C(SETUP_C), .RASLO_C(RASLO_C), .PRE_C(PRE_C),
    .ROW_W(ROW_W), .NUM_RAS(NUM_RAS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .ras_only(ras_only),
    .busy(seq_busy), .done(seq_done), .mode_ro(mode_ro),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
  );

endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk #(
  parameter int NUM_RAS     = 4,
  parameter int ROW_W       = 11,
  parameter int PEND_W      = 4,
  parameter int BACKLOG_MAX = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               grant,
  input logic               req,
  input logic               init_done,
  input logic               drive_en,
  input logic [NUM_RAS-1:0] ras_n,
  input logic [NUM_RAS-1:0] cas_n,
  input logic               we_n,
  input logic [ROW_W-1:0]   addr,
  input logic [PEND_W-1:0]  pend_cnt,
  input logic               missed,
  input logic               pwr_done,
  input logic               seq_start,
  input logic               mode_ro
);
  p_quiet_powerup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_done |-> !req);

  p_no_slots_in_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> pend_cnt == '0);

  p_start_on_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (grant && req));

  p_idle_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> (&ras_n && &cas_n));

  p_cas_leads_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n[0]) && !mode_ro) |-> (!cas_n[0] && $past(!cas_n[0])));

  p_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n) we_n);

  p_row_only_cas_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && mode_ro) |-> &cas_n);

  p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n[0] && $past(!ras_n[0])) |-> $stable(addr));

  p_strobes_grouped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((ras_n == '0 || &ras_n) && (cas_n == '0 || &cas_n)));

  p_pend_unit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt == $past(pend_cnt)) || (pend_cnt == $past(pend_cnt) + 1'b1) ||
    (pend_cnt + 1'b1 == $past(pend_cnt)));

  p_missed_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt > PEND_W'(BACKLOG_MAX)) |=> missed);

  p_missed_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(missed) |-> missed);

endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(
  .NUM_RAS(NUM_RAS), .ROW_W(ROW_W), .PEND_W(PEND_W), .BACKLOG_MAX(BACKLOG_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .init_done(init_done),
  .drive_en(drive_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
  .pend_cnt(pend_cnt), .missed(missed), .pwr_done(pwr_done),
  .seq_start(seq_start), .mode_ro(mode_ro)
);

// File: tb/dram_rfsh_sched_test.sv
module dram_rfsh_sched_test;
  // Small configuration: 20 ns clock.
  localparam int CLK   = 20;
  localparam int PWR_E = (2000 + CLK - 1) / CLK;        // 100
  localparam int REFI_E = 400 / CLK;                    // 20
  localparam int PRE_E  = (40 + CLK - 1) / CLK;         // 2
  localparam int RC_E   = (110 + CLK - 1) / CLK;        // 6
  localparam int RAS_E  = (60 + CLK - 1) / CLK;         // 3
  localparam int CSR_E  = (10 + CLK - 1) / CLK;         // 1
  localparam int LOW_E  = (RAS_E > RC_E - PRE_E) ? RAS_E : RC_E - PRE_E;  // 4
  localparam int B2B_E  = CSR_E + LOW_E + PRE_E + 1;    // 8
  localparam int BMAX   = 3;
  localparam int NINIT  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grant = 1'b0;
  logic        ras_only = 1'b0;
  logic        req, init_done, drive_en, we_n, missed;
  logic [3:0]  ras_n, cas_n, pend_cnt;
  logic [10:0] addr;

  always #10 clk = ~clk;

  dram_rfsh_sched #(
    .CLK_NS(CLK), .POWERUP_NS(2000), .REFI_NS(400), .INIT_CYC(NINIT),
    .PEND_W(4), .BACKLOG_MAX(BMAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .ras_only(ras_only),
    .req(req), .init_done(init_done), .drive_en(drive_en),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
    .pend_cnt(pend_cnt), .missed(missed)
  );

  int checks = 0;
  int errors = 0;
  bit grant_en = 1'b0;
  bit ro_expect = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Arbiter model: grant follows request, re-registered on the falling edge.
  always @(negedge clk) grant <= grant_en && req;

  // Edge monitor.
  int cyc = 0, last_fall = -1000, last_rise = -1000, cas_fall_at = -1000;
  int falls = 0, ro_falls = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, low_bad = 1'b0, first_fall = 1'b1;
  logic [10:0] exp_row = '0, held_addr = '0;
  logic [3:0]  held_cas = '1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_cas && !cas_n[0]) cas_fall_at = cyc;
      if (prev_ras && !ras_n[0]) begin
        chk(ras_n == 4'h0 && (cas_n == 4'h0 || cas_n == 4'hf), "R7 strobes grouped at fall", ras_n, 0);
        if (!first_fall) begin
          chk(cyc - last_fall >= RC_E, "R8 fall-to-fall spacing", cyc - last_fall, RC_E);
          chk(cyc - last_rise >= PRE_E, "R8 precharge width", cyc - last_rise, PRE_E);
        end
        chk((cas_n[0] == 1'b0) == !ro_expect, "R12 style follows select", cas_n[0], ro_expect);
        if (!cas_n[0]) begin
          chk(cyc - cas_fall_at >= CSR_E, "R5 cas lead", cyc - cas_fall_at, CSR_E);
          chk(we_n == 1'b1, "R5 we high", we_n, 1);
        end else begin
          chk(addr == exp_row, "R6 row address", addr, exp_row);
          ro_falls++;
          if (ro_falls == 2049) chk(addr == 11'd0, "R6 row counter wrap", addr, 0);
          exp_row = exp_row + 11'd1;
        end
        held_addr = addr;
        held_cas = cas_n;
        low_bad = 1'b0;
        first_fall = 1'b0;
        last_fall = cyc;
        falls++;
      end else if (!ras_n[0]) begin
        if (addr != held_addr || cas_n != held_cas || we_n != 1'b1 || ras_n != 4'h0)
          low_bad = 1'b1;
      end
      if (!prev_ras && ras_n[0]) begin
        chk(cyc - last_fall == LOW_E, "R8 ras low width", cyc - last_fall, LOW_E);
        chk(!low_bad, "R5 R6 pins steady while ras low", low_bad, 0);
        last_rise = cyc;
      end
      prev_ras = ras_n[0];
      prev_cas = cas_n[0];
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_fall(output int at);
    int f0;
    f0 = falls;
    while (falls == f0) @(negedge clk);
    at = last_fall;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (req || drive_en);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n, t0, t1, f0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req && !init_done && !drive_en, "R1 control outputs in reset", {req, init_done, drive_en}, 0);
    chk(ras_n == 4'hf && cas_n == 4'hf && we_n, "R1 strobes idle in reset", {ras_n, cas_n}, 8'hff);
    chk(addr == 0 && pend_cnt == 0 && !missed, "R1 counters clear", {addr, pend_cnt, missed}, 0);
    rst_n = 1'b1;
    grant_en = 1'b1;

    // R2: power-up window
    n = 0;
    do begin @(negedge clk); n++; end while (!req && n < 10000);
    chk(n == PWR_E, "R2 first request after power-up window", n, PWR_E);

    // R3: warm-up cycles
    while (!init_done) @(negedge clk);
    chk(falls == NINIT, "R3 warm-up refresh count", falls, NINIT);
    chk(pend_cnt == 0, "R3 no slots counted during warm-up", pend_cnt, 0);

    // R9: periodic spacing with immediate grant
    wait_fall(t0);
    for (int k = 0; k < 5; k++) begin
      wait_fall(t1);
      chk(t1 - t0 == REFI_E, "R9 refresh interval", t1 - t0, REFI_E);
      t0 = t1;
    end

    // R10/R11: withhold grant to build a backlog
    wait_idle();
    grant_en = 1'b0;
    n = 0;
    while (pend_cnt != 1 && n < 1000) begin @(negedge clk); n++; end
    repeat (REFI_E) @(negedge clk);
    chk(pend_cnt == 2, "R10 backlog grows one per interval", pend_cnt, 2);
    chk(req && !drive_en && ras_n == 4'hf && cas_n == 4'hf, "R4 no driving without grant", {req, drive_en}, 2'b10);
    n = 0;
    while (pend_cnt != BMAX && n < 1000) begin @(negedge clk); n++; end
    chk(!missed, "R11 flag clear at limit", missed, 0);
    n = 0;
    while (pend_cnt != BMAX + 1 && n < 1000) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(missed, "R11 flag set past limit", missed, 1);

    // Drain with grant held: back-to-back sequences
    f0 = falls;
    grant_en = 1'b1;
    wait_fall(t0);
    wait_fall(t1);
    chk(t1 - t0 == B2B_E, "R4 back-to-back spacing", t1 - t0, B2B_E);
    n = 0;
    while (pend_cnt != 0 && n < 2000) begin @(negedge clk); n++; end
    wait_idle();
    chk(falls - f0 >= BMAX + 1, "R10 backlog drained by refreshes", falls - f0, BMAX + 1);
    chk(pend_cnt == 0, "R10 backlog empty", pend_cnt, 0);
    chk(missed, "R11 flag sticky", missed, 1);

    // R6/R12: row-only style through a full counter wrap
    ras_only = 1'b1;
    ro_expect = 1'b1;
    n = 0;
    while (ro_falls < 2050 && n < 120000) begin @(negedge clk); n++; end
    chk(ro_falls >= 2050, "R6 row-only refreshes issued", ro_falls, 2050);
    finish_run();
  end

endmodule